// File: doc/BRIEF.md
# Card Capacity Descriptor Encoder

This block turns a storage size, given as a count of 512-byte sectors, into the 128-bit card-specific-data response that a memory card returns to its host. Each size belongs to one of two card classes. Sizes above 2 GiB use the high-capacity class, whose template carries a single 22-bit size field. Smaller sizes use the standard class, whose template encodes the size as a 12-bit mantissa and a 3-bit exponent. The block picks the template, computes the fields and places them across the word boundaries of the response.

A caller pulses `start` with the sector count applied. For standard sizes, the block finds the exponent by halving the size, one step per clock, until the result fits. It then pulses `done` and holds the four response words, the class bit and the error flag until the next result. A size that cannot be encoded raises `error` and zeroes the response, and `done` still pulses for it.

Top module: `csd_size_encoder`

## Requirements
- R1: While reset is held and after its release, before any result, all four response words, `hc_mode`, `done` and `error` are zero.
- R2: A sector count above 4194304 (byte size above 2 GiB) sets `hc_mode` to 1 and uses the high-capacity template: word 3 = 0x400E0032, word 2 = 0x5B590000, word 1 = 0x00007F80, word 0 = 0x0A4040DF.
- R3: In high-capacity mode the size field is floor(sectors / 1024) - 1. Its bits 15:0 are ORed into word 1 bits 31:16, and its bits 21:16 are ORed into word 2 bits 5:0.
- R4: In high-capacity mode, a size field of 2^22 or more (floor(sectors/1024) > 4194304) is an error.
- R5: In standard mode the value starts at floor(sectors / 2) KiB. It is halved once per clock while it exceeds 4096, and the mantissa is the final value minus one.
- R6: In standard mode the exponent is the number of halving steps minus 2. Fewer than 2 steps, or more than 9, is an error.
- R7: In standard mode the template is word 3 = 0x00260032, word 2 = 0x5F5A8000, word 1 = 0x3EF84FFF, word 0 = 0x928040CB. Mantissa bits 11:2 are ORed into word 2 bits 9:0, mantissa bits 1:0 into word 1 bits 31:30, and the exponent into word 1 bits 17:15.
- R8: On an error all four words are zero, `error` is 1, `hc_mode` still shows the chosen class, and `done` still pulses.
- R9: `done` is a one-cycle pulse, N+1 clocks after the edge that samples `start`, where N is the number of halving steps. N is 0 in high-capacity mode.
- R10: Between results the outputs hold their values, and a `start` that arrives while a conversion is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion of `sectors` |
| sectors | input | 64 | Storage size in 512-byte sectors |
| resp_w3 | output | 32 | Response word 3 (most significant) |
| resp_w2 | output | 32 | Response word 2 |
| resp_w1 | output | 32 | Response word 1 |
| resp_w0 | output | 32 | Response word 0 (least significant) |
| hc_mode | output | 1 | 1 when the high-capacity class was chosen |
| done | output | 1 | One-cycle pulse when a result is ready |
| error | output | 1 | The last size could not be encoded |

## Verification
The bench builds the block with its default parameters: a 64-bit sector count, a 12-bit mantissa, a 3-bit exponent and a 22-bit high-capacity field. With the full count width it can drive sizes past the 2 TiB limit of the 22-bit field and land exactly on either side of it. It can also place a size exactly at the 2 GiB class boundary, which drives the longest nine-step halving loop. Small sizes give one-step and zero-step loops that exercise the too-small error, and a start issued in the middle of the long loop checks that a running conversion is not disturbed.

// File: rtl/csd_enc_pkg.sv
package csd_enc_pkg;

  // High-capacity template, word 3 down to word 0
  localparam logic [31:0] HC_T3 = 32'h400E0032;
  localparam logic [31:0] HC_T2 = 32'h5B590000;
  localparam logic [31:0] HC_T1 = 32'h00007F80;
  localparam logic [31:0] HC_T0 = 32'h0A4040DF;

  // Standard template, word 3 down to word 0
  localparam logic [31:0] SD_T3 = 32'h00260032;
  localparam logic [31:0] SD_T2 = 32'h5F5A8000;
  localparam logic [31:0] SD_T1 = 32'h3EF84FFF;
  localparam logic [31:0] SD_T0 = 32'h928040CB;

  // Field positions that a host decoder relies on
  localparam int unsigned HC_LO_LSB   = 16; // word 1
  localparam int unsigned HC_LO_W     = 16;
  localparam int unsigned MANT_LO_W   = 2;  // word 1 top bits
  localparam int unsigned MANT_LO_LSB = 30;
  localparam int unsigned EXP_LSB     = 15; // word 1

  typedef struct packed {
    logic [31:0] w3;
    logic [31:0] w2;
    logic [31:0] w1;
    logic [31:0] w0;
  } csd_resp_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } enc_state_t;

endpackage

// File: rtl/csd_classify.sv
module csd_classify #(
  parameter int unsigned SEC_W      = 64,
  parameter int unsigned THR_SHIFT  = 22,
  parameter int unsigned HC_SHIFT   = 10,
  parameter int unsigned HC_FIELD_W = 22,
  parameter int unsigned KIB_SHIFT  = 1
) (
  input  logic [SEC_W-1:0]      sectors,
  output logic                  hc_sel,
  output logic [HC_FIELD_W-1:0] hc_field,
  output logic                  hc_overflow,
  output logic [SEC_W-1:0]      kib_init
);

  localparam logic [SEC_W-1:0] THRESHOLD = SEC_W'(1) << THR_SHIFT;
  localparam logic [SEC_W-1:0] UNIT_LIM  = SEC_W'(1) << HC_FIELD_W;

  logic [SEC_W-1:0] units;
  logic [SEC_W-1:0] units_m1;

  always_comb begin
    hc_sel      = sectors > THRESHOLD;
    units       = sectors >> HC_SHIFT;
    units_m1    = units - SEC_W'(1);
    hc_field    = units_m1[HC_FIELD_W-1:0];
    hc_overflow = units > UNIT_LIM;
    kib_init    = sectors >> KIB_SHIFT;
  end

endmodule

// File: rtl/csd_norm_loop.sv
module csd_norm_loop #(
  parameter int unsigned SEC_W  = 64,
  parameter int unsigned MANT_W = 12,
  parameter int unsigned CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_en,
  input  logic [SEC_W-1:0] kib_in,
  output logic [SEC_W-1:0] kib_q,
  output logic [CNT_W-1:0] steps_q,
  output logic             more
);

  localparam logic [SEC_W-1:0] KIB_MAX = SEC_W'(1) << MANT_W;

  logic [SEC_W-1:0] kib_n;
  logic [CNT_W-1:0] steps_n;
  logic             kib_en;

  always_comb begin
    more    = kib_q > KIB_MAX;
    kib_en  = load | (step_en & more);
    kib_n   = kib_q;
    steps_n = steps_q;
    if (load) begin
      kib_n   = kib_in;
      steps_n = '0;
    end else if (step_en && more) begin
      kib_n   = kib_q >> 1;
      steps_n = steps_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kib_q   <= '0;
      steps_q <= '0;
    end else if (kib_en) begin
      kib_q   <= kib_n;
      steps_q <= steps_n;
    end
  end

endmodule

// File: rtl/csd_field_pack.sv
module csd_field_pack
  import csd_enc_pkg::*;
#(
  parameter int unsigned SEC_W      = 64,
  parameter int unsigned MANT_W     = 12,
  parameter int unsigned EXP_W      = 3,
  parameter int unsigned EXP_BIAS   = 2,
  parameter int unsigned CNT_W      = 7,
  parameter int unsigned HC_FIELD_W = 22
) (
  input  logic                  hc,
  input  logic [HC_FIELD_W-1:0] hc_field,
  input  logic                  hc_overflow,
  input  logic [SEC_W-1:0]      kib,
  input  logic [CNT_W-1:0]      steps,
  output csd_resp_t             resp,
  output logic                  err
);

  localparam int unsigned EXP_MAX   = (1 << EXP_W) - 1;
  localparam logic [CNT_W-1:0] STEP_MIN = CNT_W'(EXP_BIAS);
  localparam logic [CNT_W-1:0] STEP_MAX = CNT_W'(EXP_BIAS + EXP_MAX);
  localparam int unsigned HC_HI_W   = HC_FIELD_W - HC_LO_W;

  logic [MANT_W-1:0] mant;
  logic [CNT_W-1:0]  exp_full;
  logic [EXP_W-1:0]  exp_f;
  logic              sd_err;
  csd_resp_t         sd_resp;
  csd_resp_t         hc_resp;

  // standard encoding
  always_comb begin
    mant     = kib[MANT_W-1:0] - MANT_W'(1);
    exp_full = steps - STEP_MIN;
    exp_f    = exp_full[EXP_W-1:0];
    sd_err   = (steps < STEP_MIN) || (steps > STEP_MAX);
    sd_resp.w3 = SD_T3;
    sd_resp.w2 = SD_T2 | 32'(mant >> MANT_LO_W);
    sd_resp.w1 = SD_T1
               | (32'(mant[MANT_LO_W-1:0]) << MANT_LO_LSB)
               | (32'(exp_f) << EXP_LSB);
    sd_resp.w0 = SD_T0;
  end

  // high-capacity encoding
  always_comb begin
    hc_resp.w3 = HC_T3;
    hc_resp.w2 = HC_T2 | 32'(hc_field[HC_FIELD_W-1 -: HC_HI_W]);
    hc_resp.w1 = HC_T1 | (32'(hc_field[HC_LO_W-1:0]) << HC_LO_LSB);
    hc_resp.w0 = HC_T0;
  end

  always_comb begin
    err  = hc ? hc_overflow : sd_err;
    resp = hc ? hc_resp : sd_resp;
    if (err) begin
      resp = '0;
    end
  end

endmodule

// File: rtl/csd_size_encoder.sv
module csd_size_encoder
  import csd_enc_pkg::*;
#(
  parameter int unsigned SEC_W        = 64,
  parameter int unsigned SECTOR_LOG2  = 9,
  parameter int unsigned KIB_LOG2     = 10,
  parameter int unsigned HC_UNIT_LOG2 = 19,
  parameter int unsigned HC_LIM_LOG2  = 31,
  parameter int unsigned MANT_W       = 12,
  parameter int unsigned EXP_W        = 3,
  parameter int unsigned EXP_BIAS     = 2,
  parameter int unsigned HC_FIELD_W   = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEC_W-1:0] sectors,
  output logic [31:0]      resp_w3,
  output logic [31:0]      resp_w2,
  output logic [31:0]      resp_w1,
  output logic [31:0]      resp_w0,
  output logic             hc_mode,
  output logic             done,
  output logic             error
);

  localparam int unsigned KIB_SHIFT = KIB_LOG2 - SECTOR_LOG2;
  localparam int unsigned HC_SHIFT  = HC_UNIT_LOG2 - SECTOR_LOG2;
  localparam int unsigned THR_SHIFT = HC_LIM_LOG2 - SECTOR_LOG2;
  localparam int unsigned CNT_W     = $clog2(SEC_W + 1);

  enc_state_t state_q, state_n;

  logic                  cls_hc;
  logic [HC_FIELD_W-1:0] cls_field;
  logic                  cls_ovf;
  logic [SEC_W-1:0]      cls_kib;

  logic                  hc_q, hc_ovf_q;
  logic [HC_FIELD_W-1:0] hc_field_q;
  logic                  cls_en;

  logic                  load, step_en, fin;
  logic [SEC_W-1:0]      kib_q;
  logic [CNT_W-1:0]      steps_q;
  logic                  more;

  csd_resp_t             pk_resp;
  logic                  pk_err;

  csd_resp_t             resp_q, resp_n;
  logic                  hc_out_q, hc_out_n;
  logic                  err_q, err_n;
  logic                  done_q;

  csd_classify #(
    .SEC_W      (SEC_W),
    .THR_SHIFT  (THR_SHIFT),
    .HC_SHIFT   (HC_SHIFT),
    .HC_FIELD_W (HC_FIELD_W),
    .KIB_SHIFT  (KIB_SHIFT)
  ) u_classify (
    .sectors     (sectors),
    .hc_sel      (cls_hc),
    .hc_field    (cls_field),
    .hc_overflow (cls_ovf),
    .kib_init    (cls_kib)
  );

  csd_norm_loop #(
    .SEC_W  (SEC_W),
    .MANT_W (MANT_W),
    .CNT_W  (CNT_W)
  ) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step_en (step_en),
    .kib_in  (cls_kib),
    .kib_q   (kib_q),
    .steps_q (steps_q),
    .more    (more)
  );

  csd_field_pack #(
    .SEC_W      (SEC_W),
    .MANT_W     (MANT_W),
    .EXP_W      (EXP_W),
    .EXP_BIAS   (EXP_BIAS),
    .CNT_W      (CNT_W),
    .HC_FIELD_W (HC_FIELD_W)
  ) u_pack (
    .hc          (hc_q),
    .hc_field    (hc_field_q),
    .hc_overflow (hc_ovf_q),
    .kib         (kib_q),
    .steps       (steps_q),
    .resp        (pk_resp),
    .err         (pk_err)
  );

  // control: next state
  always_comb begin
    load    = start && (state_q == ST_IDLE);
    step_en = (state_q == ST_BUSY) && !hc_q;
    fin     = (state_q == ST_BUSY) && (hc_q || !more);
    cls_en  = load;
    state_n = state_q;
    case (state_q)
      ST_IDLE: if (load) state_n = ST_BUSY;
      ST_BUSY: if (fin)  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // result: next values
  always_comb begin
    resp_n   = resp_q;
    hc_out_n = hc_out_q;
    err_n    = err_q;
    if (fin) begin
      resp_n   = pk_resp;
      hc_out_n = hc_q;
      err_n    = pk_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q       <= 1'b0;
      hc_ovf_q   <= 1'b0;
      hc_field_q <= '0;
    end else if (cls_en) begin
      hc_q       <= cls_hc;
      hc_ovf_q   <= cls_ovf;
      hc_field_q <= cls_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q   <= '0;
      hc_out_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (fin) begin
      resp_q   <= resp_n;
      hc_out_q <= hc_out_n;
      err_q    <= err_n;
    end
  end

  assign resp_w3 = resp_q.w3;
  assign resp_w2 = resp_q.w2;
  assign resp_w1 = resp_q.w1;
  assign resp_w0 = resp_q.w0;
  assign hc_mode = hc_out_q;
  assign error   = err_q;
  assign done    = done_q;

endmodule

// File: rtl/csd_size_encoder_chk.sv
module csd_size_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] resp_w3,
  input logic [31:0] resp_w2,
  input logic [31:0] resp_w1,
  input logic [31:0] resp_w0,
  input logic        hc_mode,
  input logic        done,
  input logic        error
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> ({resp_w3, resp_w2, resp_w1, resp_w0} == 128'd0));

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(resp_w3) && $stable(resp_w2) && $stable(resp_w1)
               && $stable(resp_w0) && $stable(hc_mode) && $stable(error)));

  // R2
  hc_template_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hc_mode && !error) |-> (resp_w3 == 32'h400E0032 && resp_w0 == 32'h0A4040DF));

  // R7
  sd_template_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hc_mode && !error) |-> (resp_w3 == 32'h00260032 && resp_w0 == 32'h928040CB));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!done && !error && !hc_mode));

endmodule

bind csd_size_encoder csd_size_encoder_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .resp_w3 (resp_w3),
  .resp_w2 (resp_w2),
  .resp_w1 (resp_w1),
  .resp_w0 (resp_w0),
  .hc_mode (hc_mode),
  .done    (done),
  .error   (error)
);

// File: tb/csd_size_encoder_bench.sv
module csd_size_encoder_bench;

  typedef struct packed {
    logic [127:0] resp;
    logic         hc;
    logic         err;
    logic [31:0]  due;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [63:0] sectors;
  logic [31:0] resp_w3, resp_w2, resp_w1, resp_w0;
  logic        hc_mode, done, error;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [31:0] cyc = 0;
  exp_t        sb_q[$];
  exp_t        last_exp;

  csd_size_encoder u_csd_size_encoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sectors (sectors),
    .resp_w3 (resp_w3),
    .resp_w2 (resp_w2),
    .resp_w1 (resp_w1),
    .resp_w0 (resp_w0),
    .hc_mode (hc_mode),
    .done    (done),
    .error   (error)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 32'd1;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // reference model built from the requirements
  function automatic exp_t model(input logic [63:0] s, input logic [31:0] now);
    exp_t        e;
    logic [63:0] u, f, kib;
    logic [11:0] m;
    int          n;
    e = '0;
    n = 0;
    if (s > 64'd4194304) begin                 // R2
      e.hc = 1'b1;
      u = s >> 10;
      f = u - 64'd1;                           // R3
      e.err = (u > 64'd4194304);               // R4
      e.resp = {32'h400E0032, 32'h5B590000 | {26'd0, f[21:16]},
                32'h00007F80 | {f[15:0], 16'd0}, 32'h0A4040DF};
    end else begin
      kib = s >> 1;                            // R5
      while (kib > 64'd4096) begin
        kib = kib >> 1;
        n++;
      end
      m = kib[11:0] - 12'd1;
      e.err = (n < 2) || (n > 9);              // R6
      e.resp = {32'h00260032, 32'h5F5A8000 | {22'd0, m[11:2]},
                32'h3EF84FFF | {m[1:0], 30'd0} | (32'(n - 2) << 15),
                32'h928040CB};                 // R7
    end
    if (e.err) e.resp = '0;                    // R8
    e.due = now + 32'(n) + 32'd2;              // R9
    return e;
  endfunction

  task automatic kick(input logic [63:0] s);
    @(negedge clk);
    sb_q.push_back(model(s, cyc));
    start   = 1'b1;
    sectors = s;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [63:0] s);
    kick(s);
    drain();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", 128'd1, 128'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        last_exp = e;
        check({resp_w3, resp_w2, resp_w1, resp_w0} == e.resp, "R3/R5/R7 response",
              {resp_w3, resp_w2, resp_w1, resp_w0}, e.resp);
        check(hc_mode == e.hc, "R2 hc_mode", 128'(hc_mode), 128'(e.hc));
        check(error == e.err, "R4/R6/R8 error", 128'(error), 128'(e.err));
        check(cyc == e.due, "R9 latency", 128'(cyc), 128'(e.due));
      end
    end
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    sectors = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({resp_w3, resp_w2, resp_w1, resp_w0, hc_mode, done, error} == '0,
          "R1 reset outputs", {resp_w3, resp_w2, resp_w1, resp_w0}, 128'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({resp_w3, resp_w2, resp_w1, resp_w0, hc_mode, done, error} == '0,
          "R1 idle after reset", {resp_w3, resp_w2, resp_w1, resp_w0}, 128'd0);

    run(64'd0);                  // R6 zero steps: too small
    run(64'd16384);              // R6 one step: too small
    run(64'd32768);              // R6 two steps, exponent 0
    run(64'd20000);              // R5 mantissa 2499
    run(64'd1000000);            // R5/R7 mid size
    run(64'd4194304);            // R6 2 GiB: nine steps, exponent 7
    run(64'd4194305);            // R2 first high-capacity size
    run(64'd123456789);          // R3 field split
    run(64'h0000_0001_0000_03FF);// R4 largest field that fits
    run(64'h0000_0001_0000_0400);// R4 first overflow
    run(64'h8000_0000_0000_0000);// R4/R8 huge size

    // R10 a start during a running conversion is ignored
    kick(64'd4194304);
    repeat (2) @(negedge clk);
    start   = 1'b1;
    sectors = 64'd4194305;
    @(negedge clk);
    start   = 1'b0;
    drain();
    repeat (15) @(negedge clk);
    // R10 outputs held while idle
    check({resp_w3, resp_w2, resp_w1, resp_w0} == last_exp.resp, "R10 hold",
          {resp_w3, resp_w2, resp_w1, resp_w0}, last_exp.resp);
    check(hc_mode == last_exp.hc && error == last_exp.err, "R10 hold flags",
          128'({hc_mode, error}), 128'({last_exp.hc, last_exp.err}));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog R9", 128'(cyc), 128'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule